// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the controller-side sender of a fixed-rate, time-division-multiplexed serial audio link. It runs on the incoming bit clock and counts out frames of 256 bit periods. For each frame it raises the frame sync line for the first 16 periods and shifts one 16-bit tag slot and twelve 20-bit data slots onto the outgoing serial data line, MSB first. Outgoing sync and data change only on the rising edge of the bit clock.

Upstream logic offers four per-frame words, each with its own valid flag: a register command address, register command data, and a left and a right 16-bit PCM playback sample. One cycle before sync rises, the block pulses a frame-start strobe. The words present in that cycle are captured at the following edge and held for the whole frame. The tag slot is built from the valid flags, and any slot that carries no valid data is sent as all zeros.

A halt input lets the link be parked to save power. It is checked only at frame boundaries, so a frame that has begun is always sent in full. While the block is halted, sync and data stay low.

Top module: `serial_frame_tx`

## Requirements
- R1: A frame lasts exactly 256 bit clocks. `frame_start_o` is high for exactly one cycle per frame: the last bit period of the previous frame, or the first cycle the link leaves the halted state. Sync rises on the next rising edge.
- R2: `sync_o` is high for the first 16 bit periods of every frame and low for the remaining 240.
- R3: The tag slot is the first 16 bits of the frame, MSB first. Tag bit 15 is 1 when any data slot is valid. Tag bit (15-k) is the valid flag of slot k, where slot 1 is the command address, slot 2 the command data, slot 3 left PCM and slot 4 right PCM. Tag bits 10 down to 0 are always 0.
- R4: Slot 1, which occupies frame bits 16 to 35 counted from the start of the frame, carries `cmd_addr_i` MSB first. Slot 2, which occupies bits 36 to 55, carries `cmd_data_i` MSB first. Each is sent only when its valid flag is set.
- R5: Slots 3 and 4 carry the 16-bit left and right samples left-justified: the sample fills slot bits 19 to 4, and slot bits 3 to 0 are 0.
- R6: Every bit of a slot whose valid flag is clear is sent as 0, and slots 5 to 12 are always all 0.
- R7: The data words and valid flags are captured at the rising edge that ends the `frame_start_o` cycle. Changes to them at any other time have no effect on the frame being sent.
- R8: `halt_i` is checked only in the last bit period of a frame. If it is high then, the current frame still completes. Afterwards `sync_o`, `sdata_o` and `frame_start_o` stay low until `halt_i` falls. `frame_start_o` then rises in the same cycle, and a new frame follows.
- R9: While `rst_n` is low, `sync_o`, `sdata_o` and `frame_start_o` are low. In the first cycle after reset is released with `halt_i` low, `frame_start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_i | input | 1 | Park the link at the next frame boundary |
| cmd_addr_i | input | 20 | Command address word for slot 1 |
| cmd_addr_vld_i | input | 1 | Slot 1 valid |
| cmd_data_i | input | 20 | Command data word for slot 2 |
| cmd_data_vld_i | input | 1 | Slot 2 valid |
| pcm_left_i | input | 16 | Left playback sample for slot 3 |
| pcm_left_vld_i | input | 1 | Slot 3 valid |
| pcm_right_i | input | 16 | Right playback sample for slot 4 |
| pcm_right_vld_i | input | 1 | Slot 4 valid |
| frame_start_o | output | 1 | One-cycle strobe: present next frame's words now |
| sync_o | output | 1 | Frame sync, high during the tag phase |
| sdata_o | output | 1 | Serial frame data, MSB first |

## Verification
Frames are driven with every slot valid, with no slot valid (tag and all data zero), with only the command slots valid, and with only the PCM slots valid using extreme sample values. Together these separate a tag bit that lands in the wrong position, a slot that is not zero-stuffed, and PCM padding on the wrong side. Some frames have their inputs scrambled right after capture, which shows whether the words are really held for the whole frame. A halt raised mid-frame and then released checks that the frame in flight finishes, that the idle line stays quiet, and that the restart strobe comes at once.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

   localparam int unsigned DEF_TAG_BITS    = 16;
   localparam int unsigned DEF_SLOT_BITS   = 20;
   localparam int unsigned DEF_DATA_SLOTS  = 12;
   localparam int unsigned DEF_SAMPLE_BITS = 16;
   localparam int unsigned DEF_SYNC_LEN    = 16;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } link_state_e;

   function automatic int unsigned frame_len(input int unsigned tag_bits,
                                             input int unsigned slot_bits,
                                             input int unsigned n_slots);
      return tag_bits + slot_bits * n_slots;
   endfunction

endpackage

// File: rtl/sfx_frame_timer.sv
module sfx_frame_timer
   import sfx_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 256,
   parameter int unsigned SYNC_LEN   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_i,
   output logic frame_start_o,
   output logic run_o,
   output logic sync_o
);

   localparam int unsigned   PW       = $clog2(FRAME_BITS);
   localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);
   localparam logic [PW-1:0] SYNC_END = PW'(SYNC_LEN);

   if (SYNC_LEN == 0 || SYNC_LEN >= FRAME_BITS) begin : g_bad_sync
      $error("sfx_frame_timer: SYNC_LEN must lie inside the frame");
   end
   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("sfx_frame_timer: FRAME_BITS too small");
   end

   link_state_e   state_q;
   logic [PW-1:0] pos_q;
   logic          at_last;

   assign at_last       = (pos_q == LAST_POS);
   assign frame_start_o = rst_n && at_last && !halt_i;
   assign run_o         = (state_q == ST_RUN);
   assign sync_o        = run_o && (pos_q < SYNC_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pos_q   <= LAST_POS;
      end else if (at_last) begin
         if (halt_i) begin
            state_q <= ST_IDLE;
         end else begin
            state_q <= ST_RUN;
            pos_q   <= '0;
         end
      end else begin
         pos_q <= pos_q + 1'b1;
      end
   end

   AST_START_THEN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |=> sync_o); // R1

   AST_SYNC_LOW_AFTER_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && pos_q == SYNC_END - 1'b1) |=> !sync_o); // R2

   AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (at_last && halt_i) |=> (!sync_o && !run_o)); // R8

endmodule

// File: rtl/sfx_frame_pack.sv
module sfx_frame_pack
   import sfx_pkg::*;
#(
   parameter int unsigned TAG_BITS   = 16,
   parameter int unsigned SLOT_BITS  = 20,
   parameter int unsigned DATA_SLOTS = 12,
   localparam int unsigned FRAME_BITS = frame_len(TAG_BITS, SLOT_BITS, DATA_SLOTS)
) (
   input  logic [DATA_SLOTS-1:0]                slot_vld_i,
   input  logic [DATA_SLOTS-1:0][SLOT_BITS-1:0] slot_data_i,
   output logic [FRAME_BITS-1:0]                frame_o
);

   localparam int unsigned RSV_BITS = TAG_BITS - 1 - DATA_SLOTS;
   localparam int unsigned DATA_TOP = FRAME_BITS - TAG_BITS - 1;

   if (TAG_BITS < DATA_SLOTS + 1) begin : g_bad_tag
      $error("sfx_frame_pack: tag slot too narrow for the slot count");
   end

   logic [TAG_BITS-1:0] tag;

   assign tag[TAG_BITS-1] = |slot_vld_i;

   for (genvar k = 0; k < DATA_SLOTS; k++) begin : g_slot
      assign tag[TAG_BITS-2-k] = slot_vld_i[k];
      assign frame_o[DATA_TOP - k*SLOT_BITS -: SLOT_BITS] =
         slot_vld_i[k] ? slot_data_i[k] : '0;
   end

   if (RSV_BITS > 0) begin : g_rsv
      assign tag[RSV_BITS-1:0] = '0;
   end

   assign frame_o[FRAME_BITS-1 -: TAG_BITS] = tag;

endmodule

// File: rtl/sfx_shift_out.sv
module sfx_shift_out #(
   parameter int unsigned FRAME_BITS = 256
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic                  run_i,
   input  logic [FRAME_BITS-1:0] frame_i,
   output logic                  sdata_o
);

   logic [FRAME_BITS-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= frame_i;
      end else begin
         sr_q <= {sr_q[FRAME_BITS-2:0], 1'b0};
      end
   end

   assign sdata_o = run_i & sr_q[FRAME_BITS-1];

   AST_LOAD_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sdata_o == $past(frame_i[FRAME_BITS-1]))); // R3

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
   import sfx_pkg::*;
#(
   parameter int unsigned TAG_BITS    = DEF_TAG_BITS,
   parameter int unsigned SLOT_BITS   = DEF_SLOT_BITS,
   parameter int unsigned DATA_SLOTS  = DEF_DATA_SLOTS,
   parameter int unsigned SAMPLE_BITS = DEF_SAMPLE_BITS,
   parameter int unsigned SYNC_LEN    = DEF_SYNC_LEN
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   halt_i,
   input  logic [SLOT_BITS-1:0]   cmd_addr_i,
   input  logic                   cmd_addr_vld_i,
   input  logic [SLOT_BITS-1:0]   cmd_data_i,
   input  logic                   cmd_data_vld_i,
   input  logic [SAMPLE_BITS-1:0] pcm_left_i,
   input  logic                   pcm_left_vld_i,
   input  logic [SAMPLE_BITS-1:0] pcm_right_i,
   input  logic                   pcm_right_vld_i,
   output logic                   frame_start_o,
   output logic                   sync_o,
   output logic                   sdata_o
);

   localparam int unsigned FRAME_BITS = frame_len(TAG_BITS, SLOT_BITS, DATA_SLOTS);
   localparam int unsigned PAD_BITS   = SLOT_BITS - SAMPLE_BITS;

   if (SAMPLE_BITS > SLOT_BITS) begin : g_bad_sample
      $error("serial_frame_tx: sample wider than a slot");
   end
   if (DATA_SLOTS < 4) begin : g_bad_slots
      $error("serial_frame_tx: at least four data slots are needed");
   end

   logic [SLOT_BITS-1:0]                left_word;
   logic [SLOT_BITS-1:0]                right_word;
   logic [DATA_SLOTS-1:0]               slot_vld;
   logic [DATA_SLOTS-1:0][SLOT_BITS-1:0] slot_data;
   logic [FRAME_BITS-1:0]               frame_word;
   logic                                run;
   logic                                any_vld;

   if (PAD_BITS == 0) begin : g_pcm_full
      assign left_word  = pcm_left_i;
      assign right_word = pcm_right_i;
   end else begin : g_pcm_pad
      assign left_word  = {pcm_left_i,  {PAD_BITS{1'b0}}};
      assign right_word = {pcm_right_i, {PAD_BITS{1'b0}}};
   end

   always_comb begin
      slot_vld     = '0;
      slot_data    = '0;
      slot_vld[0]  = cmd_addr_vld_i;
      slot_data[0] = cmd_addr_i;
      slot_vld[1]  = cmd_data_vld_i;
      slot_data[1] = cmd_data_i;
      slot_vld[2]  = pcm_left_vld_i;
      slot_data[2] = left_word;
      slot_vld[3]  = pcm_right_vld_i;
      slot_data[3] = right_word;
   end

   assign any_vld = cmd_addr_vld_i | cmd_data_vld_i | pcm_left_vld_i | pcm_right_vld_i;

   sfx_frame_timer #(
      .FRAME_BITS (FRAME_BITS),
      .SYNC_LEN   (SYNC_LEN)
   ) u_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .halt_i        (halt_i),
      .frame_start_o (frame_start_o),
      .run_o         (run),
      .sync_o        (sync_o)
   );

   sfx_frame_pack #(
      .TAG_BITS   (TAG_BITS),
      .SLOT_BITS  (SLOT_BITS),
      .DATA_SLOTS (DATA_SLOTS)
   ) u_pack (
      .slot_vld_i  (slot_vld),
      .slot_data_i (slot_data),
      .frame_o     (frame_word)
   );

   sfx_shift_out #(
      .FRAME_BITS (FRAME_BITS)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (frame_start_o),
      .run_i   (run),
      .frame_i (frame_word),
      .sdata_o (sdata_o)
   );

   AST_TAG_FRAME_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |=> (sdata_o == $past(any_vld))); // R3

   AST_QUIET_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!sdata_o && !sync_o)); // R8

endmodule

// File: tb/tb_serial_frame_tx.sv
`timescale 1ns/1ps
module tb_serial_frame_tx;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        halt_i;
   logic [19:0] cmd_addr_i;
   logic        cmd_addr_vld_i;
   logic [19:0] cmd_data_i;
   logic        cmd_data_vld_i;
   logic [15:0] pcm_left_i;
   logic        pcm_left_vld_i;
   logic [15:0] pcm_right_i;
   logic        pcm_right_vld_i;
   logic        frame_start_o;
   logic        sync_o;
   logic        sdata_o;

   always #2.5 clk = ~clk;

   serial_frame_tx dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .halt_i          (halt_i),
      .cmd_addr_i      (cmd_addr_i),
      .cmd_addr_vld_i  (cmd_addr_vld_i),
      .cmd_data_i      (cmd_data_i),
      .cmd_data_vld_i  (cmd_data_vld_i),
      .pcm_left_i      (pcm_left_i),
      .pcm_left_vld_i  (pcm_left_vld_i),
      .pcm_right_i     (pcm_right_i),
      .pcm_right_vld_i (pcm_right_vld_i),
      .frame_start_o   (frame_start_o),
      .sync_o          (sync_o),
      .sdata_o         (sdata_o)
   );

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   bit          finished = 0;
   logic [255:0] exp_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [255:0] build_frame(
      input logic [19:0] a, input logic av, input logic [19:0] d, input logic dv,
      input logic [15:0] l, input logic lv, input logic [15:0] r, input logic rv);
      logic [255:0] f;
      f = '0;
      f[255]     = av | dv | lv | rv;
      f[254]     = av;
      f[253]     = dv;
      f[252]     = lv;
      f[251]     = rv;
      f[239:220] = av ? a : 20'h0;
      f[219:200] = dv ? d : 20'h0;
      f[199:180] = lv ? {l, 4'h0} : 20'h0;
      f[179:160] = rv ? {r, 4'h0} : 20'h0;
      return f;
   endfunction

   // Driver: called at a point where frame_start_o is high
   task automatic drive_frame(
      input logic [19:0] a, input logic av, input logic [19:0] d, input logic dv,
      input logic [15:0] l, input logic lv, input logic [15:0] r, input logic rv,
      input bit scramble);
      cmd_addr_i = a;  cmd_addr_vld_i = av;
      cmd_data_i = d;  cmd_data_vld_i = dv;
      pcm_left_i = l;  pcm_left_vld_i = lv;
      pcm_right_i = r; pcm_right_vld_i = rv;
      exp_q.push_back(build_frame(a, av, d, dv, l, lv, r, rv));
      @(posedge clk);
      @(negedge clk);
      if (scramble) begin
         // R7: inputs changed after capture must not affect this frame
         cmd_addr_i = 20'($urandom);  cmd_addr_vld_i = ~av;
         cmd_data_i = 20'($urandom);  cmd_data_vld_i = ~dv;
         pcm_left_i = 16'($urandom);  pcm_left_vld_i = ~lv;
         pcm_right_i = 16'($urandom); pcm_right_vld_i = ~rv;
      end
   endtask

   task automatic wait_fs;
      while (!frame_start_o) @(negedge clk);
   endtask

   // Monitor / scoreboard
   initial begin
      logic [255:0] got;
      logic [255:0] exp;
      bit           prev_sync;
      bit           pend_r1;
      bit           fs_end;
      bit           sync_ok;
      prev_sync = 1'b0;
      pend_r1   = 1'b0;
      forever begin
         @(negedge clk);
         if (pend_r1) begin
            check(sync_o === 1'b1, "R1", "next frame starts 256 clocks later", 32'(sync_o), 32'h1);
            pend_r1 = 1'b0;
         end
         if (rst_n && sync_o && !prev_sync) begin
            got     = '0;
            sync_ok = 1'b1;
            fs_end  = 1'b0;
            for (int idx = 0; idx < 256; idx++) begin
               if (idx != 0) @(negedge clk);
               got[255-idx] = sdata_o;
               if (sync_o !== (idx < 16)) sync_ok = 1'b0;
               if (idx < 255 && frame_start_o) fs_end = 1'b1; // stray strobe marker
               if (idx == 255) begin
                  check(frame_start_o === !halt_i && !fs_end, "R1",
                        "frame_start_o in last bit period", 32'(frame_start_o), 32'(!halt_i));
                  fs_end = frame_start_o;
               end
            end
            check(sync_ok, "R2", "sync 16 high then 240 low", 32'(sync_ok), 32'h1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R1", "unexpected frame", 32'h1, 32'h0);
            end else begin
               exp = exp_q.pop_front();
               check(got[255:240] === exp[255:240], "R3", "tag slot",
                     32'(got[255:240]), 32'(exp[255:240]));
               check(got[239:220] === exp[239:220], "R4", "slot 1 command address",
                     32'(got[239:220]), 32'(exp[239:220]));
               check(got[219:200] === exp[219:200], "R4", "slot 2 command data",
                     32'(got[219:200]), 32'(exp[219:200]));
               check(got[199:180] === exp[199:180], "R5", "slot 3 left PCM",
                     32'(got[199:180]), 32'(exp[199:180]));
               check(got[179:160] === exp[179:160], "R5", "slot 4 right PCM",
                     32'(got[179:160]), 32'(exp[179:160]));
               check(got[159:0] === 160'h0, "R6", "slots 5..12 zero",
                     32'(got[159:128]), 32'h0);
            end
            pend_r1   = fs_end;
            prev_sync = 1'b0;
         end else begin
            prev_sync = sync_o;
         end
      end
   end

   // Stimulus
   initial begin
      bit quiet;
      rst_n  = 1'b0;
      halt_i = 1'b0;
      cmd_addr_i = '0; cmd_addr_vld_i = 1'b0;
      cmd_data_i = '0; cmd_data_vld_i = 1'b0;
      pcm_left_i = '0; pcm_left_vld_i = 1'b0;
      pcm_right_i = '0; pcm_right_vld_i = 1'b0;
      repeat (4) @(negedge clk);
      check(sync_o === 1'b0 && sdata_o === 1'b0 && frame_start_o === 1'b0, "R9",
            "outputs low in reset", {29'h0, sync_o, sdata_o, frame_start_o}, 32'h0);
      rst_n = 1'b1;
      #1;
      check(frame_start_o === 1'b1, "R9", "first strobe after reset", 32'(frame_start_o), 32'h1);

      // All slots valid, inputs scrambled after capture (R7)
      drive_frame(20'hA5C3F, 1, 20'h1234E, 1, 16'hBEEF, 1, 16'h8001, 1, 1);
      wait_fs;
      // No slot valid: tag and data all zero (R6)
      drive_frame(20'hFFFFF, 0, 20'hFFFFF, 0, 16'hFFFF, 0, 16'hFFFF, 0, 0);
      wait_fs;
      // Command slots only (R4)
      drive_frame(20'h80001, 1, 20'h7FFFE, 1, 16'hFFFF, 0, 16'hFFFF, 0, 1);
      wait_fs;
      // PCM slots only, extreme samples (R5)
      drive_frame(20'hFFFFF, 0, 20'hFFFFF, 0, 16'hFFFF, 1, 16'h0001, 1, 0);
      wait_fs;
      // Mixed: right only, scrambled (R7)
      drive_frame(20'h0, 0, 20'h0, 0, 16'h0, 0, 16'hC35A, 1, 1);
      wait_fs;

      // Halt raised mid-frame (R8)
      drive_frame(20'h13579, 1, 20'h0, 0, 16'h4242, 1, 16'h0, 0, 0);
      halt_i = 1'b1;
      repeat (258) @(negedge clk);
      quiet = 1'b1;
      for (int i = 0; i < 150; i++) begin
         if (sync_o !== 1'b0 || sdata_o !== 1'b0 || frame_start_o !== 1'b0) quiet = 1'b0;
         @(negedge clk);
      end
      check(quiet, "R8", "line quiet while halted", 32'(quiet), 32'h1);
      halt_i = 1'b0;
      #1;
      check(frame_start_o === 1'b1, "R8", "strobe on halt release", 32'(frame_start_o), 32'h1);
      drive_frame(20'h2468A, 1, 20'hFEDCB, 1, 16'h7FFF, 1, 16'h8000, 1, 1);
      wait_fs;
      drive_frame(20'h00001, 1, 20'h0, 0, 16'h0, 0, 16'h0, 0, 0);

      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule